// File: doc/BRIEF.md
# Three-Valued Primitive Gate Evaluator

This block computes the output of one primitive gate with `N_IN` inputs, where every signal carries one of three values: logic 0, logic 1, or unknown (X). An unknown input may stand for either a 0 or a 1. Four gate kinds are supported: AND, OR, NAND and NOR. Each kind is described by two bits. One bit is the controlling value, the input level that alone fixes the output. The other bit says whether the output is inverted. The output comes from two counts: how many inputs sit at the controlling level and how many are unknown. No truth table is used.

A bulk load writes the gate kind and all input values at once, and both counts are rebuilt from scratch. After that, single-pin change events carry the pin index, the value the pin held before and its new value. The counts are then adjusted from the old and new values alone, which is the incremental mode. The block also keeps its own image of the pins. When the self-check input is high, a full scan of that image is compared against the incremental result, and any disagreement is flagged. The output is registered, and a one-cycle flag marks every cycle in which it takes a new value.

Top module: `tvl_gate_eval`

## Requirements
- R1: Values are 2-bit codes: 00 is logic 0, 01 is logic 1, 10 is X, and 11 is also taken as X. The output always uses 10 for X and never drives 11. After reset every pin is X, the gate kind is AND, `out_val` is 10, and `out_chg` and `chk_err` are 0.
- R2: The gate code puts the controlling value in bit 0 and the inversion in bit 1: 00 AND, 01 OR, 10 NAND, 11 NOR. The code is captured only on a bulk load.
- R3: If any input equals the controlling value c, the output is c XOR i.
- R4: If no input is controlling and at least one is X, the output is X (10).
- R5: If no input is controlling and none is X, the output is (NOT c) XOR i.
- R6: A bulk load replaces all pins and the gate kind and recomputes both counts. The resulting output appears on the clock edge that takes the load.
- R7: A change event adjusts both counts using only its carried old and new values, not the stored pin. A count never goes below 0 or above `N_IN`: a step that would leave that range leaves the count unchanged. An event whose pin index is not below `N_IN` is ignored.
- R8: When a bulk load and a change event arrive in the same cycle, the load wins and the change is dropped entirely.
- R9: `out_chg` is high for exactly the cycle in which `out_val` holds a value different from the one it held the cycle before.
- R10: When `check_en` is high with a stimulus, `chk_err` goes high on the next edge, for one cycle, if the count-based output differs from a full scan of the stored pins. When `check_en` is low, `chk_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_gate | input | 2 | Gate code taken on a bulk load |
| load_vld | input | 1 | Bulk load strobe |
| load_vals | input | 2*N_IN | All pin values; pin k sits in bits [2k+1:2k] |
| chg_vld | input | 1 | Single-pin change strobe |
| chg_pin | input | IW | Index of the changing pin |
| chg_old | input | 2 | Value the pin held before the change |
| chg_new | input | 2 | New value of the pin |
| check_en | input | 1 | Enables the full-scan cross-check |
| out_val | output | 2 | Evaluated gate output |
| out_chg | output | 1 | One-cycle pulse when the output changed |
| chk_err | output | 1 | Cross-check mismatch pulse |

## Verification
Every result is due one clock edge after its stimulus. A load or change presented before a rising edge shows its output, its change flag and its cross-check verdict just after that same edge. The bench drives each stimulus at a falling edge and samples all three outputs 1 ns after the following rising edge. It then applies the next stimulus at the next falling edge, so no rising edge passes unobserved. The expected values come from a bench model that mirrors the saturating counts and a separate scan of the bench's own copy of the pins. Wrong old values are injected on purpose, both with and without the cross-check enabled.

// File: rtl/tvl_pkg.sv
package tvl_pkg;

    typedef logic [1:0] tv_t;

    localparam tv_t TV_ZERO = 2'b00;
    localparam tv_t TV_ONE  = 2'b01;
    localparam tv_t TV_UNK  = 2'b10;

    // bit 1: inversion, bit 0: controlling value
    typedef struct packed {
        logic inv;
        logic ctl;
    } gate_t;

    function automatic logic tv_unknown(tv_t v);
        return v[1];
    endfunction

    function automatic logic tv_controls(tv_t v, logic c);
        return !v[1] && (v[0] == c);
    endfunction

    function automatic tv_t tv_resolve(logic any_ctl, logic any_unk, gate_t g);
        if (any_ctl) return {1'b0, g.ctl ^ g.inv};
        if (any_unk) return TV_UNK;
        return {1'b0, ~g.ctl ^ g.inv};
    endfunction

endpackage

// File: rtl/tvl_scan.sv
module tvl_scan
    import tvl_pkg::*;
#(
    parameter int N_IN = 8,
    parameter int CW   = $clog2(N_IN + 1)
) (
    input  logic [2*N_IN-1:0] vals,
    input  gate_t             g,
    output logic [CW-1:0]     n_ctl,
    output logic [CW-1:0]     n_unk
);

    logic [N_IN-1:0] ctl_hit;
    logic [N_IN-1:0] unk_hit;

    for (genvar k = 0; k < N_IN; k++) begin : g_pin
        assign ctl_hit[k] = tv_controls(vals[2*k +: 2], g.ctl);
        assign unk_hit[k] = tv_unknown(vals[2*k +: 2]);
    end

    assign n_ctl = CW'($countones(ctl_hit));
    assign n_unk = CW'($countones(unk_hit));

endmodule

// File: rtl/tvl_counts.sv
module tvl_counts
    import tvl_pkg::*;
#(
    parameter int N_IN = 8,
    parameter int CW   = $clog2(N_IN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_en,
    input  logic [CW-1:0] load_ctl,
    input  logic [CW-1:0] load_unk,
    input  logic          chg_en,
    input  tv_t           old_v,
    input  tv_t           new_v,
    input  gate_t         g,
    output logic [CW-1:0] ctl_nxt,
    output logic [CW-1:0] unk_nxt,
    output logic [CW-1:0] ctl_q,
    output logic [CW-1:0] unk_q
);

    localparam logic [CW-1:0] FULL = CW'(N_IN);

    function automatic logic [CW-1:0] step(logic [CW-1:0] cnt, logic dec, logic inc);
        if (dec && !inc) return (cnt == '0) ? cnt : cnt - 1'b1;
        if (inc && !dec) return (cnt == FULL) ? cnt : cnt + 1'b1;
        return cnt;
    endfunction

    always_comb begin
        if (load_en) begin
            ctl_nxt = load_ctl;
            unk_nxt = load_unk;
        end else if (chg_en) begin
            ctl_nxt = step(ctl_q, tv_controls(old_v, g.ctl), tv_controls(new_v, g.ctl));
            unk_nxt = step(unk_q, tv_unknown(old_v), tv_unknown(new_v));
        end else begin
            ctl_nxt = ctl_q;
            unk_nxt = unk_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            unk_q <= FULL;
        end else begin
            ctl_q <= ctl_nxt;
            unk_q <= unk_nxt;
        end
    end

endmodule

// File: rtl/tvl_gate_eval.sv
module tvl_gate_eval
    import tvl_pkg::*;
#(
    parameter int N_IN = 8,
    localparam int CW  = $clog2(N_IN + 1),
    localparam int IW  = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        load_gate,
    input  logic              load_vld,
    input  logic [2*N_IN-1:0] load_vals,
    input  logic              chg_vld,
    input  logic [IW-1:0]     chg_pin,
    input  logic [1:0]        chg_old,
    input  logic [1:0]        chg_new,
    input  logic              check_en,
    output logic [1:0]        out_val,
    output logic              out_chg,
    output logic              chk_err
);

    gate_t             gate_q, gate_nxt, gate_ld;
    logic [2*N_IN-1:0] pins_q, pins_nxt;
    logic              chg_ok;
    logic [CW-1:0]     ld_ctl, ld_unk, sc_ctl, sc_unk;
    logic [CW-1:0]     ctl_nxt, unk_nxt, ctl_q, unk_q;
    tv_t               inc_res, scan_res;

    assign gate_ld  = gate_t'(load_gate);
    assign gate_nxt = load_vld ? gate_ld : gate_q;
    assign chg_ok   = chg_vld && !load_vld && (int'(chg_pin) < N_IN);

    always_comb begin
        pins_nxt = pins_q;
        if (load_vld) begin
            pins_nxt = load_vals;
        end else if (chg_ok) begin
            pins_nxt[2*int'(chg_pin) +: 2] = chg_new;
        end
    end

    tvl_scan #(.N_IN(N_IN), .CW(CW)) u_scan_load (
        .vals  (load_vals),
        .g     (gate_ld),
        .n_ctl (ld_ctl),
        .n_unk (ld_unk)
    );

    tvl_scan #(.N_IN(N_IN), .CW(CW)) u_scan_chk (
        .vals  (pins_nxt),
        .g     (gate_nxt),
        .n_ctl (sc_ctl),
        .n_unk (sc_unk)
    );

    tvl_counts #(.N_IN(N_IN), .CW(CW)) u_counts (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_vld),
        .load_ctl (ld_ctl),
        .load_unk (ld_unk),
        .chg_en   (chg_ok),
        .old_v    (chg_old),
        .new_v    (chg_new),
        .g        (gate_q),
        .ctl_nxt  (ctl_nxt),
        .unk_nxt  (unk_nxt),
        .ctl_q    (ctl_q),
        .unk_q    (unk_q)
    );

    assign inc_res  = tv_resolve(ctl_nxt != '0, unk_nxt != '0, gate_nxt);
    assign scan_res = tv_resolve(sc_ctl != '0, sc_unk != '0, gate_nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q  <= '0;
            pins_q  <= {N_IN{TV_UNK}};
            out_val <= TV_UNK;
            out_chg <= 1'b0;
            chk_err <= 1'b0;
        end else begin
            gate_q  <= gate_nxt;
            pins_q  <= pins_nxt;
            out_val <= inc_res;
            out_chg <= (inc_res != out_val);
            chk_err <= check_en && (inc_res != scan_res);
        end
    end

endmodule

// File: rtl/tvl_gate_eval_chk.sv
module tvl_gate_eval_chk
    import tvl_pkg::*;
#(
    parameter int N_IN = 8,
    parameter int CW   = $clog2(N_IN + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          check_en,
    input gate_t         gate_q,
    input logic [CW-1:0] ctl_q,
    input logic [CW-1:0] unk_q,
    input logic [1:0]    out_val,
    input logic          out_chg,
    input logic          chk_err
);

    // R1
    canon_out_chk: assert property (@(posedge clk) disable iff (rst)
        out_val != 2'b11);

    // R3
    ctl_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q != '0) |-> (out_val == {1'b0, gate_q.ctl ^ gate_q.inv}));

    // R4
    unk_out_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q == '0 && unk_q != '0) |-> (out_val == TV_UNK));

    // R5
    clean_out_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q == '0 && unk_q == '0) |-> (out_val == {1'b0, ~gate_q.ctl ^ gate_q.inv}));

    // R7
    ctl_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q <= CW'(N_IN)) && (unk_q <= CW'(N_IN)));

    // R9
    chg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_chg |-> (out_val != $past(out_val)));

    // R9
    no_chg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !out_chg |-> $stable(out_val));

    // R10
    err_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(check_en) |-> !chk_err);

endmodule

bind tvl_gate_eval tvl_gate_eval_chk #(.N_IN(N_IN), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .check_en (check_en),
    .gate_q   (gate_q),
    .ctl_q    (ctl_q),
    .unk_q    (unk_q),
    .out_val  (out_val),
    .out_chg  (out_chg),
    .chk_err  (chk_err)
);

// File: tb/tvl_gate_eval_tb.sv
`timescale 1ns/1ps
module tvl_gate_eval_tb;

    localparam int N  = 8;
    localparam int IW = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [1:0]     load_gate = '0;
    logic           load_vld = 1'b0;
    logic [2*N-1:0] load_vals = '0;
    logic           chg_vld = 1'b0;
    logic [IW-1:0]  chg_pin = '0;
    logic [1:0]     chg_old = '0;
    logic [1:0]     chg_new = '0;
    logic           check_en = 1'b0;
    logic [1:0]     out_val;
    logic           out_chg;
    logic           chk_err;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    logic [1:0] mpin [N];
    logic [1:0] mg;
    int         mctl, munk;
    logic [1:0] mout;

    always #2.5 clk = ~clk;

    tvl_gate_eval #(.N_IN(N)) u_dut (
        .clk(clk), .rst(rst), .load_gate(load_gate), .load_vld(load_vld),
        .load_vals(load_vals), .chg_vld(chg_vld), .chg_pin(chg_pin),
        .chg_old(chg_old), .chg_new(chg_new), .check_en(check_en),
        .out_val(out_val), .out_chg(out_chg), .chk_err(chk_err)
    );

    function automatic bit is_unk(logic [1:0] v);
        return v[1];
    endfunction

    function automatic bit is_ctl(logic [1:0] v, logic c);
        return !v[1] && (v[0] == c);
    endfunction

    function automatic logic [1:0] resolve(bit ac, bit au, logic [1:0] g);
        if (ac) return {1'b0, g[0] ^ g[1]};
        if (au) return 2'b10;
        return {1'b0, ~g[0] ^ g[1]};
    endfunction

    function automatic int sat(int cnt, bit dec, bit inc);
        if (dec && !inc) return (cnt == 0) ? 0 : cnt - 1;
        if (inc && !dec) return (cnt == N) ? N : cnt + 1;
        return cnt;
    endfunction

    task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic apply(input bit ld, input logic [2*N-1:0] lv, input logic [1:0] lg,
                         input bit cv, input int cp, input logic [1:0] co,
                         input logic [1:0] cn, input bit ce, input string tag);
        logic [1:0] exp, sexp;
        bit expchg, experr;
        int sctl, sunk;
        @(negedge clk);
        load_vld = ld; load_vals = lv; load_gate = lg;
        chg_vld = cv; chg_pin = cp[IW-1:0]; chg_old = co; chg_new = cn;
        check_en = ce;
        if (ld) begin
            mg = lg; mctl = 0; munk = 0;
            for (int k = 0; k < N; k++) begin
                mpin[k] = lv[2*k +: 2];
                if (is_ctl(mpin[k], mg[0])) mctl++;
                if (is_unk(mpin[k])) munk++;
            end
        end else if (cv && cp < N) begin
            mctl = sat(mctl, is_ctl(co, mg[0]), is_ctl(cn, mg[0]));
            munk = sat(munk, is_unk(co), is_unk(cn));
            mpin[cp] = cn;
        end
        sctl = 0; sunk = 0;
        for (int k = 0; k < N; k++) begin
            if (is_ctl(mpin[k], mg[0])) sctl++;
            if (is_unk(mpin[k])) sunk++;
        end
        exp    = resolve(mctl > 0, munk > 0, mg);
        sexp   = resolve(sctl > 0, sunk > 0, mg);
        expchg = (exp != mout);
        experr = ce && (exp != sexp);
        mout   = exp;
        @(posedge clk);
        #1;
        if (mctl > 0)      chk({tag, "/R3 output"}, out_val, exp);
        else if (munk > 0) chk({tag, "/R4 output"}, out_val, exp);
        else               chk({tag, "/R5 output"}, out_val, exp);
        chk({tag, "/R9 change flag"}, {1'b0, out_chg}, {1'b0, expchg});
        chk({tag, "/R10 check error"}, {1'b0, chk_err}, {1'b0, experr});
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no completion, expected end of run");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < N; k++) mpin[k] = 2'b10;
        mg = 2'b00; mctl = 0; munk = N; mout = 2'b10;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 reset out_val", out_val, 2'b10);
        chk("R1 reset out_chg", {1'b0, out_chg}, 2'b00);
        chk("R1 reset chk_err", {1'b0, chk_err}, 2'b00);
        @(negedge clk);
        rst = 1'b0;

        // R6 load AND, all ones
        apply(1, 16'h5555, 2'b00, 0, 0, 2'b00, 2'b00, 1, "R6 AND load");
        // R7 incremental changes
        apply(0, '0, 2'b00, 1, 3, 2'b01, 2'b00, 1, "R7 pin to 0");
        apply(0, '0, 2'b00, 1, 5, 2'b01, 2'b10, 1, "R7 pin to X");
        apply(0, '0, 2'b00, 1, 3, 2'b00, 2'b01, 1, "R7 ctl leaves");
        // R1 code 11 treated as X
        apply(0, '0, 2'b00, 1, 5, 2'b10, 2'b11, 1, "R1 code 11");
        apply(0, '0, 2'b00, 1, 5, 2'b11, 2'b01, 1, "R1 from 11");
        // R2 gate codes
        apply(1, 16'h0000, 2'b10, 0, 0, 2'b00, 2'b00, 1, "R2 NAND");
        apply(1, 16'h5555, 2'b11, 0, 0, 2'b00, 2'b00, 1, "R2 NOR");
        apply(1, 16'hAAAA, 2'b01, 0, 0, 2'b00, 2'b00, 1, "R2 OR all X");
        apply(1, 16'h0000, 2'b01, 0, 0, 2'b00, 2'b00, 1, "R2 OR all 0");
        // R8 load beats change
        apply(1, 16'h5555, 2'b00, 1, 0, 2'b01, 2'b00, 1, "R8 load+chg");
        apply(0, '0, 2'b00, 0, 0, 2'b00, 2'b00, 1, "R8 idle after");
        // R7 saturation at zero with wrong old value
        apply(0, '0, 2'b00, 1, 2, 2'b00, 2'b01, 1, "R7 saturate");
        // R10 mismatch flagged, then suppressed
        apply(0, '0, 2'b00, 1, 2, 2'b00, 2'b00, 1, "R10 mismatch on");
        apply(0, '0, 2'b00, 1, 4, 2'b01, 2'b01, 0, "R10 mismatch off");
        apply(1, 16'h5555, 2'b00, 0, 0, 2'b00, 2'b00, 1, "R6 resync");

        for (int s = 0; s < 600; s++) begin
            int op, cp;
            logic [1:0] co, cn;
            op = int'($urandom % 10);
            if (op == 0) begin
                apply(1, 16'($urandom), 2'($urandom), 0, 0, 2'b00, 2'b00,
                      1'($urandom), "R6 random load");
            end else if (op == 1) begin
                apply(0, '0, 2'b00, 0, 0, 2'b00, 2'b00, 1'($urandom), "R9 random idle");
            end else begin
                cp = int'($urandom % N);
                cn = 2'($urandom);
                co = ($urandom % 8 == 0) ? 2'($urandom) : mpin[cp];
                apply(0, '0, 2'b00, 1, cp, co, cn, 1'($urandom), "R7 random change");
            end
        end
        apply(0, '0, 2'b00, 0, 0, 2'b00, 2'b00, 0, "R9 final idle");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule